// File: doc/BRIEF.md
# Addressable Cell Switch Node

This block is the digital control for one switch node in a reconfigurable solar cell array. The nodes sit on one shared clock, one shared serial data line and one shared reset. Each node has a fixed address, set by a parameter when it is built. An array of N cells uses N-1 nodes, so 32 cells need 31 nodes. The host streams packets on the data line with no gaps. Each packet carries a target address and the on/off state of the three switches around a cell. These switches tie the cell to the negative rail, chain it in series with the next cell, or tie it to the positive rail.

Every node shifts in every bit, but only the node whose address matches the packet acts on it. That node loads all three switch controls on one clock edge, so one packet reconfigures a whole cell in a single step. Every other node keeps its switches exactly as they were. Incomplete packets and nodes that are not addressed never disturb the outputs.

Top module: `cell_switch_node`

## Requirements
- R1: A packet is exactly 9 bits long. Packet boundaries repeat every 9 rising clock edges, counted from the first edge after reset is released. The internal bit position never reaches 9.
- R2: Packet layout, sent most significant bit first and sampled on the rising edge: bit 8 = negative-rail switch, bit 7 = series switch, bit 6 = positive-rail switch, bits 5..0 = target address. A 1 closes a switch, so the pattern 100 in bits 8..6 closes only the negative-rail switch.
- R3: When the address field of a completed packet equals NODE_ADDR, all three switch outputs take bits 8..6 on the same rising edge that samples the 9th bit.
- R4: When the address field of a completed packet differs from NODE_ADDR, the switch outputs keep their previous values.
- R5: The switch outputs never change on any edge other than the 9th edge of a packet. A packet cut short by reset has no effect, and the packet that follows the reset is decoded correctly.
- R6: Reset is synchronous and active-high. It clears the bit position and the shift register and opens all three switches. The outputs read 000 after the reset edge.
- R7: Several nodes on the same clock, data and reset lines act independently. A packet changes only the node it addresses.
- R8: Any 6-bit address from 0 to 63 works as a node address, including both end values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; data is sampled on its rising edge |
| rst | input | 1 | Shared synchronous active-high reset |
| sdata | input | 1 | Shared serial packet line, most significant bit first |
| sw_neg_o | output | 1 | Close the switch from the cell to the negative rail |
| sw_ser_o | output | 1 | Close the switch that chains the cell in series with its neighbour |
| sw_pos_o | output | 1 | Close the switch from the cell to the positive rail |

## Verification
The hardest case to reach is a packet that stops partway. The node has no framing input, so a broken packet can only be seen through how the next packet lines up. The bench stops a packet after four bits and asserts reset. It then sends a full packet to the same node and confirms that the outputs first clear and then take the new pattern exactly, which shows that the bit position was put back in step. The bench also checks that the outputs hold during the first eight bits of every packet. It sweeps all 64 addresses across a bank of four nodes at addresses 42, 0, 21 and 63, so the end addresses and every case of one node being addressed while the others are not are covered.

// File: rtl/cell_switch_pkg.sv
package cell_switch_pkg;

    // Number of switches driven per cell; fixes the control field width.
    localparam int SW_COUNT = 3;

    // Order matches the packet: the first control bit on the wire is neg.
    typedef struct packed {
        logic neg;
        logic ser;
        logic pos;
    } sw_ctrl_t;

endpackage

// File: rtl/cell_switch_shifter.sv
module cell_switch_shifter #(
    parameter int PKT_W = 9,
    parameter int CNT_W = $clog2(PKT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdata,
    output logic [PKT_W-1:0] pkt_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

    typedef struct packed {
        logic [PKT_W-2:0] hist;
        logic [CNT_W-1:0] cnt;
    } shf_state_t;

    shf_state_t st_d, st_q;
    logic [PKT_W-1:0] word;
    logic             last_bit;

    always_comb begin
        word     = {st_q.hist, sdata};
        last_bit = (st_q.cnt == LAST);
        st_d     = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.hist = word[PKT_W-2:0];
            st_d.cnt  = last_bit ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pkt_o  = word;
    assign done_o = last_bit & ~rst;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/cell_switch_match.sv
module cell_switch_match #(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] NODE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    logic [ADDR_W-1:0] bit_eq;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(addr_i[i] ^ NODE_ADDR[i]);
    end

    assign hit_o = &bit_eq;

endmodule

// File: rtl/cell_switch_latch.sv
module cell_switch_latch
    import cell_switch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  sw_ctrl_t ctrl_i,
    output sw_ctrl_t ctrl_o
);

    sw_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (rst) begin
            ctrl_d = '0;
        end else if (load) begin
            ctrl_d = ctrl_i;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/cell_switch_node.sv
module cell_switch_node
    import cell_switch_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] NODE_ADDR = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic sdata,
    output logic sw_neg_o,
    output logic sw_ser_o,
    output logic sw_pos_o
);

    localparam int PKT_W = ADDR_W + SW_COUNT;
    localparam int CNT_W = $clog2(PKT_W);

    logic [PKT_W-1:0] pkt;
    logic             done;
    logic [CNT_W-1:0] bit_cnt;
    logic             hit;
    logic             load;
    sw_ctrl_t         ctrl_new;
    sw_ctrl_t         ctrl_cur;

    cell_switch_shifter #(
        .PKT_W(PKT_W),
        .CNT_W(CNT_W)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .sdata (sdata),
        .pkt_o (pkt),
        .done_o(done),
        .cnt_o (bit_cnt)
    );

    cell_switch_match #(
        .ADDR_W   (ADDR_W),
        .NODE_ADDR(NODE_ADDR)
    ) u_match (
        .addr_i(pkt[ADDR_W-1:0]),
        .hit_o (hit)
    );

    always_comb begin
        ctrl_new = sw_ctrl_t'(pkt[PKT_W-1:ADDR_W]);
        load     = done & hit;
    end

    cell_switch_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .ctrl_i(ctrl_new),
        .ctrl_o(ctrl_cur)
    );

    assign sw_neg_o = ctrl_cur.neg;
    assign sw_ser_o = ctrl_cur.ser;
    assign sw_pos_o = ctrl_cur.pos;

endmodule

// File: rtl/cell_switch_node_chk.sv
module cell_switch_node_chk #(
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] NODE_ADDR = '0,
    parameter int                PKT_W     = ADDR_W + 3,
    parameter int                CNT_W     = $clog2(PKT_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             sdata,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [2:0]       sw
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

    // Independent framing reference built from the ports only.
    logic [CNT_W-1:0] ref_cnt;
    logic [PKT_W-2:0] ref_hist;
    logic [PKT_W-1:0] ref_pkt;
    logic             ref_end;
    logic             ref_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cnt  <= '0;
            ref_hist <= '0;
        end else begin
            ref_cnt  <= (ref_cnt == LAST) ? '0 : ref_cnt + 1'b1;
            ref_hist <= ref_pkt[PKT_W-2:0];
        end
    end

    assign ref_pkt = {ref_hist, sdata};
    assign ref_end = (ref_cnt == LAST);
    assign ref_hit = (ref_pkt[ADDR_W-1:0] == NODE_ADDR);

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < CNT_W'(PKT_W));

    p_cnt_sync_r1: assert property (@(posedge clk) disable iff (rst)
        bit_cnt == ref_cnt);

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_end && ref_hit) |=> sw == $past(ref_pkt[PKT_W-1:ADDR_W]));

    p_miss_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ref_end && !ref_hit) |=> $stable(sw));

    p_partial_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ref_end |=> $stable(sw));

    p_reset_off_r6: assert property (@(posedge clk)
        rst |=> sw == 3'b000);

endmodule

bind cell_switch_node cell_switch_node_chk #(
    .ADDR_W   (ADDR_W),
    .NODE_ADDR(NODE_ADDR)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sdata  (sdata),
    .bit_cnt(bit_cnt),
    .sw     ({sw_neg_o, sw_ser_o, sw_pos_o})
);

// File: tb/cell_switch_node_tb.sv
module cell_switch_node_tb;

    localparam int NN = 4;
    localparam logic [5:0] ADDRS [NN] = '{6'd42, 6'd0, 6'd21, 6'd63};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdata = 1'b0;
    logic [3*NN-1:0] got_flat;
    logic [2:0] exp_sw [NN];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cell_switch_node #(.NODE_ADDR(ADDRS[0])) u_dut (
        .clk(clk), .rst(rst), .sdata(sdata),
        .sw_neg_o(got_flat[2]), .sw_ser_o(got_flat[1]), .sw_pos_o(got_flat[0])
    );

    for (genvar i = 1; i < NN; i++) begin : g_peer
        cell_switch_node #(.NODE_ADDR(ADDRS[i])) u_peer (
            .clk(clk), .rst(rst), .sdata(sdata),
            .sw_neg_o(got_flat[3*i+2]), .sw_ser_o(got_flat[3*i+1]),
            .sw_pos_o(got_flat[3*i])
        );
    end

    task automatic check(input string req, input int node,
                         input logic [2:0] act, input logic [2:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s node%0d (addr %0d): got %b expected %b",
                     req, node, ADDRS[node], act, expv);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NN; i++)
            check(req, i, got_flat[3*i +: 3], exp_sw[i]);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic drive_bit(input logic b);
        sdata = b;
        @(negedge clk);
    endtask

    // Full packet, MSB first; outputs must hold until the 9th bit (R5).
    task automatic send_pkt(input logic [2:0] ctrl, input logic [5:0] addr);
        logic [8:0] p;
        p = {ctrl, addr};
        for (int k = 8; k >= 0; k--) begin
            drive_bit(p[k]);
            if (k > 0) check_all("R5 hold mid-packet");
        end
        for (int i = 0; i < NN; i++)
            if (ADDRS[i] == addr) exp_sw[i] = ctrl;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NN; i++) exp_sw[i] = 3'b000;
        check_all("R6 reset opens switches");
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        for (int i = 0; i < NN; i++) exp_sw[i] = 3'b000;
        repeat (3) @(negedge clk);
        check_all("R6 initial reset");
        rst = 1'b0;

        // R2: single pattern 100 closes only the negative-rail switch.
        send_pkt(3'b100, 6'd42);
        check("R2 pattern 100", 0, got_flat[2:0], 3'b100);
        check_all("R7 others untouched");

        // R3: every control code on the DUT.
        for (int c = 0; c < 8; c++) begin
            send_pkt(3'(c), 6'd42);
            check_all("R3 all three load together");
        end

        // R4, R7, R8: sweep every address with varying control codes.
        for (int a = 0; a < 64; a++) begin
            send_pkt(3'((a * 5 + 3) % 8), 6'(a));
            check_all("R4 R7 R8 address sweep");
        end

        // R4: address one bit away from the DUT.
        send_pkt(~exp_sw[0], 6'd43);
        check_all("R4 near-miss address");

        // R5, R1: cut a matching packet short, reset, then resend.
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
        drive_bit(1'b0);
        check_all("R5 partial packet");
        do_reset();
        send_pkt(3'b011, 6'd42);
        check("R1 realigned after reset", 0, got_flat[2:0], 3'b011);
        send_pkt(3'b110, 6'd63);
        send_pkt(3'b101, 6'd0);
        check_all("R1 back-to-back framing");

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule